// File: doc/BRIEF.md
# Video Event Interrupt Source Unit

This unit sits beside a display timing generator and turns its four timing strobes into one interrupt request. Each strobe sets a sticky bit in a pending register. The strobes mark the beginning of a line, the beginning of horizontal blanking, the beginning of a frame and the beginning of vertical blanking. A separately written enable register decides which pending bits may drive the single level-sensitive request line. Software clears a pending bit only by servicing it, with a write-one-to-clear access. Acknowledging the interrupt at the interrupt controller does not clear it.

The unit also holds a bank of timing parameters in two copies. Software may write the shadow copy at any time. The whole bank moves into the active copy on the clock edge that registers a frame-start strobe, so a new configuration takes effect at one frame boundary.

Register map (word addresses on a 4-bit address bus, 16-bit data): 0x0 pending, 0x1 enable, 0x4 to 0x7 shadow parameters 0 to 3, 0x8 to 0xB active parameters 0 to 3 (read only). Reads return data combinationally from the address. Writes take effect on the rising clock edge where the write strobe is high. Unmapped addresses read zero.

Top module: `vid_irq_unit`

## Requirements
- R1: After reset, pending, enable, every shadow parameter and every active parameter read zero, and irq_o is low.
- R2: On each rising edge where evt_i bit k is high, pending bit k becomes 1 whatever the enable setting. The bit order is 0 line start, 1 line end (horizontal blanking), 2 frame start, 3 frame end (vertical blanking).
- R3: irq_o is high exactly while the bitwise AND of enable and pending is nonzero, and it stays high until that AND becomes zero.
- R4: A pending bit clears only when a 1 is written to that bit position at address 0x0. Writing 0 to a pending bit and writing the enable register leave pending unchanged.
- R5: When a strobe and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R6: With enable all zero, pending bits still set and read back, and irq_o stays low.
- R7: A write to address 0x4+k updates shadow parameter k, which reads back at once. Active parameter k does not change until a frame-start strobe, and other strobes do not load it.
- R8: On the edge that registers a frame-start strobe, every active parameter takes the value its shadow held before that edge. A shadow write in the same cycle lands in the shadow only.
- R9: Writes to active parameter addresses 0x8 to 0xB have no effect.
- R10: The enable register holds bits 3:0 of the written data and reads back with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Timing event strobes, one bit per event |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the unit with its default values: four events, four 16-bit parameters and a 4-bit address. At this size every pending bit, every enable bit and every shadow and active register can be reached through the bus. The bench can therefore check the event-over-clear race, polling with interrupts disabled, and a shadow write that lands in the same cycle as a frame-start copy, one register at a time.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int EVT_N = 4;
  typedef enum logic [1:0] {
    EVT_LINE_START  = 2'd0,
    EVT_LINE_END    = 2'd1,
    EVT_FRAME_START = 2'd2,
    EVT_FRAME_END   = 2'd3
  } evt_idx_e;
  localparam logic [3:0] ADDR_PEND     = 4'h0;
  localparam logic [3:0] ADDR_EN       = 4'h1;
  localparam logic [3:0] ADDR_SHD_BASE = 4'h4;
  localparam logic [3:0] ADDR_ACT_BASE = 4'h8;
endpackage

// File: rtl/vid_irq_pending.sv
module vid_irq_pending #(
  parameter int EVT_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [EVT_N-1:0] clr_i,
  output logic [EVT_N-1:0] pend_o
);
  logic [EVT_N-1:0] pend_q;

  for (genvar k = 0; k < EVT_N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[k] <= 1'b0;
      else if (evt_i[k]) pend_q[k] <= 1'b1;  // event beats clear
      else if (clr_i[k]) pend_q[k] <= 1'b0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> pend_q[k]);
    assert_clear_only_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[k]) |-> ($past(clr_i[k]) && !$past(evt_i[k])));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vid_irq_params.sv
module vid_irq_params #(
  parameter int NUM_PARAMS = 4,
  parameter int PARAM_W    = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PARAMS-1:0]               wr_en_i,
  input  logic [PARAM_W-1:0]                  wdata_i,
  input  logic                                load_i,
  output logic [NUM_PARAMS-1:0][PARAM_W-1:0]  shadow_o,
  output logic [NUM_PARAMS-1:0][PARAM_W-1:0]  active_o
);
  logic [NUM_PARAMS-1:0][PARAM_W-1:0] shadow_q, active_q;

  for (genvar k = 0; k < NUM_PARAMS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[k] <= '0;
        active_q[k] <= '0;
      end else begin
        if (wr_en_i[k]) shadow_q[k] <= wdata_i;
        if (load_i)     active_q[k] <= shadow_q[k];  // pre-edge shadow
      end
    end

    assert_active_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(active_q[k]));
    assert_active_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (active_q[k] == $past(shadow_q[k])));
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/vid_irq_unit.sv
module vid_irq_unit
  import vid_irq_pkg::*;
#(
  parameter int NUM_PARAMS = 4,
  parameter int PARAM_W    = 16,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [EVT_N-1:0]      evt_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  irq_o
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_EN);

  logic [EVT_N-1:0]                   en_q, pend, clr;
  logic [NUM_PARAMS-1:0]              shd_wr;
  logic [NUM_PARAMS-1:0][PARAM_W-1:0] shadow, active;

  assign clr = (bus_we_i && bus_addr_i == A_PEND) ? bus_wdata_i[EVT_N-1:0] : '0;

  for (genvar k = 0; k < NUM_PARAMS; k++) begin : g_dec
    assign shd_wr[k] = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_SHD_BASE + k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= '0;
    else if (bus_we_i && bus_addr_i == A_EN)  en_q <= bus_wdata_i[EVT_N-1:0];
  end

  vid_irq_pending #(.EVT_N(EVT_N)) i_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  vid_irq_params #(.NUM_PARAMS(NUM_PARAMS), .PARAM_W(PARAM_W)) i_params (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (shd_wr),
    .wdata_i  (bus_wdata_i[PARAM_W-1:0]),
    .load_i   (evt_i[EVT_FRAME_START]),
    .shadow_o (shadow),
    .active_o (active)
  );

  assign irq_o = |(en_q & pend);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_PEND) bus_rdata_o = DATA_W'(pend);
    if (bus_addr_i == A_EN)   bus_rdata_o = DATA_W'(en_q);
    for (int k = 0; k < NUM_PARAMS; k++) begin
      if (bus_addr_i == ADDR_W'(ADDR_SHD_BASE + k)) bus_rdata_o = DATA_W'(shadow[k]);
      if (bus_addr_i == ADDR_W'(ADDR_ACT_BASE + k)) bus_rdata_o = DATA_W'(active[k]);
    end
  end

  assert_irq_quiet_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  assert_irq_drop_by_sw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(bus_we_i && (bus_addr_i == A_PEND || bus_addr_i == A_EN)));
endmodule

// File: tb/test_vid_irq_unit.sv
module test_vid_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_irq_unit i_vid_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, starting and ending at a falling edge
  task automatic cyc(input logic [3:0] e, input logic w, input logic [3:0] a, input logic [15:0] d);
    evt = e; we = w; addr = a; wdata = d;
    @(negedge clk);
    evt = '0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d); chk("R1 reg", d, 16'h0);
    end
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_poll;
    logic [15:0] d;
    for (int k = 0; k < 4; k++) begin
      cyc(4'(1 << k), 1'b0, 4'h0, 16'h0);
      rd(4'h0, d); chk("R2 R6 pend order", d, 16'((2 << k) - 1));
      chk("R6 irq low", 16'(irq), 16'h0);
    end
    cyc(4'h0, 1'b1, 4'h0, 16'h000F);
    rd(4'h0, d); chk("R4 clear all", d, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    cyc(4'h0, 1'b1, 4'h1, 16'hFFF4);
    rd(4'h1, d); chk("R10 enable", d, 16'h0004);
    cyc(4'h8, 1'b0, 4'h0, 16'h0);
    chk("R3 masked", 16'(irq), 16'h0);
    cyc(4'h4, 1'b0, 4'h0, 16'h0);
    chk("R3 irq up", 16'(irq), 16'h1);
    @(negedge clk); @(negedge clk);
    chk("R3 irq held", 16'(irq), 16'h1);
    cyc(4'h0, 1'b1, 4'h0, 16'h0);
    rd(4'h0, d); chk("R4 write zero", d, 16'h000C);
    cyc(4'h0, 1'b1, 4'h0, 16'h0008);
    rd(4'h0, d); chk("R4 clear bit3", d, 16'h0004);
    chk("R3 still up", 16'(irq), 16'h1);
    cyc(4'h0, 1'b1, 4'h0, 16'h0004);
    chk("R3 irq down", 16'(irq), 16'h0);
    cyc(4'h0, 1'b1, 4'h1, 16'h0);
  endtask

  task automatic t_race;
    logic [15:0] d;
    cyc(4'h3, 1'b0, 4'h0, 16'h0);
    cyc(4'h2, 1'b1, 4'h0, 16'h0003);
    rd(4'h0, d); chk("R5 event wins", d, 16'h0002);
    cyc(4'h0, 1'b1, 4'h1, 16'h000F);
    rd(4'h0, d); chk("R4 enable write keeps pend", d, 16'h0002);
    chk("R3 irq enable", 16'(irq), 16'h1);
    cyc(4'h0, 1'b1, 4'h1, 16'h0);
    chk("R6 disable drops", 16'(irq), 16'h0);
    cyc(4'h0, 1'b1, 4'h0, 16'h000F);
  endtask

  task automatic t_params;
    logic [15:0] d;
    for (int k = 0; k < 4; k++) cyc(4'h0, 1'b1, 4'(4 + k), 16'(16'h1000 + k * 16'h0111));
    for (int k = 0; k < 4; k++) begin
      rd(4'(4 + k), d); chk("R7 shadow", d, 16'(16'h1000 + k * 16'h0111));
      rd(4'(8 + k), d); chk("R7 active held", d, 16'h0);
    end
    cyc(4'hB, 1'b1, 4'h8, 16'hDEAD);
    rd(4'h8, d); chk("R7 other events no load", d, 16'h0);
    cyc(4'h0, 1'b1, 4'h9, 16'hDEAD);
    rd(4'h9, d); chk("R9 active read only", d, 16'h0);
    cyc(4'h4, 1'b0, 4'h0, 16'h0);
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), d); chk("R8 load", d, 16'(16'h1000 + k * 16'h0111));
    end
    cyc(4'h4, 1'b1, 4'h4, 16'hBEEF);
    rd(4'h8, d); chk("R8 same-cycle old value", d, 16'h1000);
    rd(4'h4, d); chk("R8 same-cycle shadow", d, 16'hBEEF);
    cyc(4'h4, 1'b0, 4'h0, 16'h0);
    rd(4'h8, d); chk("R8 next frame", d, 16'hBEEF);
    cyc(4'h0, 1'b1, 4'h0, 16'h000F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_poll;
    t_irq;
    t_race;
    t_params;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule